// File: doc/BRIEF.md
# Windowed Multi-Stage Viterbi Traceback Engine

This block recovers decoded bits from the survivor decisions that a Viterbi forward pass has already written to a decision memory. Each memory location stores, for a group of sixteen trellis states, a short pre-resolved segment of 1 to 4 input bits. This is the segment length the forward pass used. The engine walks backwards through that memory, and each read moves it a whole segment (S stages) back in time. The engine uses the segment to rebuild the previous state index and the next read address. The state index is K-1 bits wide, where K is the constraint length (5 to 9). The engine fixes the newest input bit at bit 0 of that index.

A frame of N segment steps is split into decode windows of W steps, starting at step 0. The traceback for an intermediate window starts from state 0 at step min(window end + C, N-1), where C is the convergence distance. Groups traced in that convergence stretch are thrown away. The final window starts from state 0 at step N-1, because the frame is tail-terminated. The engine collects the groups of a window in a last-in-first-out buffer. It then presents them in forward time order, with the bit order inside each group reversed so that the oldest bit comes first. A one-cycle finish pulse tells the processor or DMA that the frame is complete.

The controller is a state machine with five states:
- IDLE: waits for `start`.
- LOAD: computes the window bounds and issues the first read.
- TRACE: makes one step per cycle.
- DRAIN: pops one group per cycle.
- FINISH: raises `done`.

It moves between these states as follows:
- IDLE goes to LOAD on `start`.
- LOAD always goes to TRACE.
- TRACE goes to DRAIN after the step equal to the window base.
- DRAIN goes back to LOAD when the last group of a non-final window leaves the buffer, and to FINISH when the final window is empty.
- FINISH always goes back to IDLE.

Top module: `viterbi_traceback`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `out_valid` and `done` are 0.
- R2: A `start` seen in IDLE latches the configuration and raises `busy` from the next cycle until the cycle after `done`. A `start` seen while busy changes neither the outputs nor the timing.
- R3: The read address is `{step, state[7:4]}`, which is step*16 + (state index / 16). The first read of a frame is for the starting step of window 0 with state 0. This read is on `mem_addr` in the cycle after `start` is taken. The memory returns the word one cycle after it samples the address.
- R4: The segment for a state s is bits [4*(s mod 16) +: 4] of the returned word, and only its low S bits are used. The previous state is {segment, state >> S}, truncated to K-1 bits.
- R5: A window of base b, last output step e and starting step t0 takes exactly 1 + (t0-b+1) + (e-b+1) cycles. `done` is high in the cycle after the last window's final group.
- R6: Windows cover steps [0,W-1], [W,2W-1] and so on. The last window ends at step N-1, and every step yields exactly one output group.
- R7: An intermediate window's traceback starts from state 0 at step min(e+C, N-1). Groups for steps above e are discarded.
- R8: For a tail-terminated frame decoded as a single window, the output bits equal the frame's input bits exactly.
- R9: Groups leave in increasing step order. Bit i of `out_bits` is the input bit of time step*S+i, and bits at positions S and above are 0.
- R10: `done` is a single-cycle pulse, and it is preceded by exactly N groups with `out_valid` high.
- R11: A window setting of 0, or one above 64, acts as 64. A step count of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only in IDLE) |
| cfg_k | input | 4 | Constraint length, 5..9 |
| cfg_seg | input | 3 | Segment length S, 1..4 |
| cfg_steps | input | 8 | Frame length N in segment steps |
| cfg_win | input | 7 | Window length W in steps |
| cfg_conv | input | 8 | Convergence distance C in steps |
| busy | output | 1 | Frame in progress |
| mem_addr | output | 12 | Decision memory read address |
| mem_rdata | input | 64 | Decision word, one cycle after the address |
| out_valid | output | 1 | An output group is present |
| out_bits | output | 4 | Decoded group, oldest bit in bit 0 |
| done | output | 1 | One-cycle frame-finished pulse |

## Verification
In TRACE, the cycle that consumes a returned word must also form the next address from the state that word yields. If the pairing is wrong by one cycle, the engine reads the segment belonging to a different state. Every run therefore fills the non-survivor fields with state-dependent noise. The bench compares each output group against a step-by-step model built from R4 and R7, and the exact tail-frame comparison catches any slip. The second case is a window boundary, where the last DRAIN pop and the base update for the next LOAD share one cycle. Multi-window frames, one-step windows, and a convergence distance that runs past the frame end are checked against the exact cycle count of R5.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

    typedef enum logic [2:0] {
        TB_IDLE,
        TB_LOAD,
        TB_TRACE,
        TB_DRAIN,
        TB_FINISH
    } tb_fsm_e;

endpackage

// File: rtl/tbk_seg_select.sv
module tbk_seg_select #(
    parameter int STW     = 8,
    parameter int MAX_SEG = 4,
    parameter int SPW     = 16,
    parameter int KW_W    = 4,
    parameter int SEGL_W  = 3
) (
    input  logic [SPW*MAX_SEG-1:0] word,
    input  logic [STW-1:0]         cur,
    input  logic [SEGL_W-1:0]      seg_len,
    input  logic [KW_W-1:0]        kw,
    output logic [STW-1:0]         prev,
    output logic [MAX_SEG-1:0]     group
);
    localparam int SEL_W = $clog2(SPW);

    logic [MAX_SEG-1:0] field;
    logic [MAX_SEG:0]   seg_mask;
    logic [STW:0]       st_mask;
    logic [MAX_SEG-1:0] seg;
    logic [STW-1:0]     placed;
    logic [KW_W-1:0]    shift_up;

    always_comb begin
        field    = word[cur[SEL_W-1:0]*MAX_SEG +: MAX_SEG];
        seg_mask = ((MAX_SEG+1)'(1) << seg_len) - (MAX_SEG+1)'(1);
        st_mask  = ((STW+1)'(1) << kw) - (STW+1)'(1);
        seg      = field & seg_mask[MAX_SEG-1:0];
        shift_up = kw - KW_W'(seg_len);
        placed   = STW'(seg) << shift_up;
        prev     = ((cur >> seg_len) | placed) & st_mask[STW-1:0];
        group    = cur[MAX_SEG-1:0] & seg_mask[MAX_SEG-1:0];
    end

endmodule

// File: rtl/tbk_lifo.sv
module tbk_lifo #(
    parameter int DEPTH = 64,
    parameter int W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [W-1:0]     store [DEPTH];
    logic [CNT_W-1:0] top_idx;

    assign top_idx = count - CNT_W'(1);
    assign dout    = (count == '0) ? '0 : store[top_idx[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push && !pop) begin
            store[count[IDX_W-1:0]] <= din;
            count <= count + CNT_W'(1);
        end else if (pop && !push) begin
            count <= count - CNT_W'(1);
        end
    end

    a_r6_lifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));
    a_r9_lifo_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    a_r6_lifo_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/viterbi_traceback.sv
module viterbi_traceback
    import tbk_pkg::*;
#(
    parameter int MAX_K   = 9,
    parameter int MAX_SEG = 4,
    parameter int SPW     = 16,
    parameter int STEP_W  = 8,
    parameter int MAX_WIN = 64,
    localparam int STW    = MAX_K - 1,
    localparam int SEL_W  = $clog2(SPW),
    localparam int HI_W   = STW - SEL_W,
    localparam int AW     = STEP_W + HI_W,
    localparam int WORD_W = SPW * MAX_SEG,
    localparam int WIN_W  = $clog2(MAX_WIN + 1),
    localparam int SEGL_W = $clog2(MAX_SEG + 1),
    localparam int KW_W   = $clog2(STW + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [KW_W-1:0]    cfg_k,
    input  logic [SEGL_W-1:0]  cfg_seg,
    input  logic [STEP_W-1:0]  cfg_steps,
    input  logic [WIN_W-1:0]   cfg_win,
    input  logic [STEP_W-1:0]  cfg_conv,
    output logic               busy,
    output logic [AW-1:0]      mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               out_valid,
    output logic [MAX_SEG-1:0] out_bits,
    output logic               done
);
    localparam int EXT_W  = STEP_W + WIN_W + 1;
    localparam int CNT_W  = $clog2(MAX_WIN + 1);
    localparam int SEGI_W = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1;

    tb_fsm_e fsm, fsm_nx;

    logic [KW_W-1:0]    kw_r;
    logic [SEGL_W-1:0]  seg_r;
    logic [STEP_W-1:0]  nlast_r, conv_r, base_r, wlast_r, tb_step;
    logic [WIN_W-1:0]   win_r;
    logic [STW-1:0]     tb_state;

    logic [STW-1:0]     prev_state;
    logic [MAX_SEG-1:0] group;
    logic [MAX_SEG-1:0] lifo_dout;
    logic [CNT_W-1:0]   lifo_cnt;
    logic               push, pop;
    logic               trace_last, drain_last, frame_last;

    logic [EXT_W-1:0]   end_cand, start_cand, nl_ext;
    logic [STEP_W-1:0]  wlast_c, tfirst_c;
    logic [STEP_W-1:0]  a_step;
    logic [STW-1:0]     a_state;

    // Window bounds for the window that starts at base_r
    always_comb begin
        nl_ext     = EXT_W'(nlast_r);
        end_cand   = EXT_W'(base_r) + EXT_W'(win_r) - EXT_W'(1);
        wlast_c    = (end_cand >= nl_ext) ? nlast_r : end_cand[STEP_W-1:0];
        start_cand = EXT_W'(wlast_c) + EXT_W'(conv_r);
        tfirst_c   = (start_cand >= nl_ext) ? nlast_r : start_cand[STEP_W-1:0];
    end

    tbk_seg_select #(
        .STW(STW), .MAX_SEG(MAX_SEG), .SPW(SPW), .KW_W(KW_W), .SEGL_W(SEGL_W)
    ) u_sel (
        .word(mem_rdata), .cur(tb_state), .seg_len(seg_r), .kw(kw_r),
        .prev(prev_state), .group(group)
    );

    tbk_lifo #(.DEPTH(MAX_WIN), .W(MAX_SEG)) u_lifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din(group), .dout(lifo_dout), .count(lifo_cnt)
    );

    assign trace_last = (tb_step == base_r);
    assign drain_last = (lifo_cnt == CNT_W'(1));
    assign frame_last = (wlast_r == nlast_r);

    // Next-state logic
    always_comb begin
        fsm_nx = fsm;
        unique case (fsm)
            TB_IDLE:   if (start) fsm_nx = TB_LOAD;
            TB_LOAD:   fsm_nx = TB_TRACE;
            TB_TRACE:  if (trace_last) fsm_nx = TB_DRAIN;
            TB_DRAIN:  if (drain_last) fsm_nx = frame_last ? TB_FINISH : TB_LOAD;
            TB_FINISH: fsm_nx = TB_IDLE;
            default:   fsm_nx = TB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) fsm <= TB_IDLE;
        else        fsm <= fsm_nx;
    end

    // Outputs and datapath controls
    always_comb begin
        busy      = (fsm != TB_IDLE);
        done      = 1'b0;
        out_valid = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        a_step    = tb_step;
        a_state   = tb_state;
        unique case (fsm)
            TB_IDLE:   ;
            TB_LOAD: begin
                a_step  = tfirst_c;
                a_state = '0;
            end
            TB_TRACE: begin
                push    = (tb_step <= wlast_r);
                a_step  = tb_step - STEP_W'(1);
                a_state = prev_state;
            end
            TB_DRAIN: begin
                pop       = 1'b1;
                out_valid = 1'b1;
            end
            TB_FINISH: done = 1'b1;
            default:   ;
        endcase
        mem_addr = {a_step, a_state[STW-1:SEL_W]};
    end

    // Time reversal inside a group: oldest bit to position 0
    for (genvar gi = 0; gi < MAX_SEG; gi++) begin : g_rev
        logic [SEGL_W-1:0] src;
        assign src          = seg_r - SEGL_W'(gi + 1);
        assign out_bits[gi] = (SEGL_W'(gi) < seg_r) ? lifo_dout[src[SEGI_W-1:0]] : 1'b0;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kw_r     <= '0;
            seg_r    <= '0;
            nlast_r  <= '0;
            win_r    <= '0;
            conv_r   <= '0;
            base_r   <= '0;
            wlast_r  <= '0;
            tb_step  <= '0;
            tb_state <= '0;
        end else begin
            unique case (fsm)
                TB_IDLE: if (start) begin
                    kw_r    <= cfg_k - KW_W'(1);
                    seg_r   <= cfg_seg;
                    nlast_r <= (cfg_steps == '0) ? '0 : cfg_steps - STEP_W'(1);
                    win_r   <= (cfg_win == '0 || cfg_win > WIN_W'(MAX_WIN))
                               ? WIN_W'(MAX_WIN) : cfg_win;
                    conv_r  <= cfg_conv;
                    base_r  <= '0;
                end
                TB_LOAD: begin
                    wlast_r  <= wlast_c;
                    tb_step  <= tfirst_c;
                    tb_state <= '0;
                end
                TB_TRACE: if (!trace_last) begin
                    tb_step  <= tb_step - STEP_W'(1);
                    tb_state <= prev_state;
                end
                TB_DRAIN: if (drain_last && !frame_last) begin
                    base_r <= wlast_r + STEP_W'(1);
                end
                TB_FINISH: ;
                default: ;
            endcase
        end
    end

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_read_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == TB_TRACE) |-> (tb_step == $past(mem_addr[AW-1:HI_W])));
    a_r4_state_width: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == TB_TRACE) |-> ((tb_state >> kw_r) == '0));
    a_r7_trace_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == TB_TRACE) |-> (tb_step >= base_r && tb_step <= nlast_r));
    a_r9_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lifo_cnt != '0));
    a_r11_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lifo_cnt <= CNT_W'(win_r)));

endmodule

// File: tb/sim_viterbi_traceback.sv
`timescale 1ns/1ps
module sim_viterbi_traceback;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cfg_k = 4'd5;
    logic [2:0]  cfg_seg = 3'd1;
    logic [7:0]  cfg_steps = 8'd1;
    logic [6:0]  cfg_win = 7'd1;
    logic [7:0]  cfg_conv = 8'd0;
    logic        busy, out_valid, done;
    logic [11:0] mem_addr;
    logic [63:0] mem_q = '0;
    logic [3:0]  out_bits;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int g_k, g_s, g_n, exp_T, exp_a0;
    bit u_bits [0:1023];
    logic [3:0] exp_g [0:255];

    // k, seg, steps, win, conv, flags(bit0 exact, bit1 late start, bit2 clamping)
    localparam logic [39:0] VEC [9] = '{
        {4'd7, 4'd3, 8'd20, 8'd20,  8'd0,  8'd1},
        {4'd9, 4'd4, 8'd30, 8'd8,   8'd6,  8'd0},
        {4'd5, 4'd1, 8'd40, 8'd10,  8'd3,  8'd0},
        {4'd6, 4'd2, 8'd25, 8'd7,   8'd30, 8'd0},
        {4'd8, 4'd4, 8'd17, 8'd0,   8'd5,  8'd5},
        {4'd7, 4'd3, 8'd33, 8'd5,   8'd4,  8'd2},
        {4'd5, 4'd4, 8'd12, 8'd1,   8'd2,  8'd0},
        {4'd9, 4'd2, 8'd70, 8'd100, 8'd9,  8'd4},
        {4'd5, 4'd2, 8'd0,  8'd3,   8'd1,  8'd4}
    };

    viterbi_traceback u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k), .cfg_seg(cfg_seg),
        .cfg_steps(cfg_steps), .cfg_win(cfg_win), .cfg_conv(cfg_conv), .busy(busy),
        .mem_addr(mem_addr), .mem_rdata(mem_q), .out_valid(out_valid),
        .out_bits(out_bits), .done(done)
    );

    always #2.5 clk = ~clk;

    function automatic logic [3:0] hsh(int a, int b);
        logic [31:0] x;
        x = (a * 32'd2654435761) ^ (b * 32'd40503) ^ 32'h5bd1e995;
        x = x ^ (x >> 15);
        return x[7:4];
    endfunction

    // True encoder state after step t, newest bit at bit 0
    function automatic int strue(int t);
        int s = 0;
        if (t < 0) return 0;
        for (int i = 0; i < g_k - 1; i++) begin
            int idx = t * g_s + g_s - 1 - i;
            if (idx >= 0 && u_bits[idx]) s |= (1 << i);
        end
        return s;
    endfunction

    function automatic logic [3:0] fld(int t, int s);
        if (s == strue(t)) return 4'(strue(t - 1) >> (g_k - 1 - g_s));
        return hsh(t, s);
    endfunction

    function automatic logic [63:0] word_of(logic [11:0] a);
        logic [63:0] w;
        int t  = int'(a >> 4);
        int hi = int'(a & 12'hF);
        for (int j = 0; j < 16; j++) w[j*4 +: 4] = fld(t, hi * 16 + j);
        return w;
    endfunction

    always @(posedge clk) mem_q <= word_of(mem_addr);

    function automatic logic [3:0] rev(int s, int n);
        logic [3:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = s[n - 1 - i];
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic build(int k, int s, int n, int win, int conv);
        int nl, weff, base, wl, st, cs, kw, first;
        g_k = k; g_s = s; kw = k - 1;
        nl = (n == 0) ? 0 : n - 1;
        g_n = nl + 1;
        weff = (win == 0 || win > 64) ? 64 : win;
        for (int i = 0; i < 1024; i++) u_bits[i] = 1'b0;
        for (int i = 0; i < g_n * s; i++) u_bits[i] = hsh(i, 777)[0];
        for (int i = g_n * s - kw; i < g_n * s; i++) if (i >= 0) u_bits[i] = 1'b0;
        base = 0; exp_T = 0; first = 1;
        while (base <= nl) begin
            wl = (base + weff - 1 > nl) ? nl : base + weff - 1;
            st = (wl + conv > nl) ? nl : wl + conv;
            if (first) exp_a0 = st * 16;
            first = 0;
            cs = 0;
            for (int t = st; t >= base; t--) begin
                if (t <= wl) exp_g[t] = rev(cs, s);
                cs = ((cs >> s) | ((int'(fld(t, cs)) & ((1 << s) - 1)) << (kw - s)))
                     & ((1 << kw) - 1);
            end
            exp_T += 1 + (st - base + 1) + (wl - base + 1);
            base = wl + 1;
        end
    endtask

    task automatic run_frame(logic [39:0] v);
        int k, idx;
        logic [7:0] fl;
        fl = v[7:0];
        build(int'(v[39:36]), int'(v[35:32]), int'(v[31:24]), int'(v[23:16]), int'(v[15:8]));
        @(negedge clk);
        cfg_k = v[39:36]; cfg_seg = v[34:32]; cfg_steps = v[31:24];
        cfg_win = v[22:16]; cfg_conv = v[15:8]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(mem_addr == 12'(exp_a0), "R3 first address", int'(mem_addr), exp_a0);
        k = 0; idx = 0;
        while (!done && k < 20000) begin
            if (out_valid) begin
                if (idx < g_n) begin
                    chk(out_bits == exp_g[idx], "R4/R7/R9 group", int'(out_bits), int'(exp_g[idx]));
                    if (fl[0]) begin
                        logic [3:0] tru = '0;
                        for (int i = 0; i < g_s; i++) tru[i] = u_bits[idx * g_s + i];
                        chk(out_bits == tru, "R8 exact bits", int'(out_bits), int'(tru));
                    end
                end
                idx++;
            end
            if (fl[1] && k == 3) begin
                start = 1'b1; cfg_k = 4'd5; cfg_seg = 3'd1; cfg_steps = 8'd3;
            end
            if (k == 4) start = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(done == 1'b1, "R10 done seen", int'(done), 1);
        chk(idx == g_n, "R6 group count", idx, g_n);
        chk(k == exp_T, "R5 cycle count", k, exp_T);
        if (fl[2]) chk(k == exp_T, "R11 clamped frame timing", k, exp_T);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 single pulse then idle", int'({done, busy}), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !out_valid && !done, "R1 in reset", int'({busy, out_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !out_valid && !done, "R1 after reset", int'({busy, out_valid, done}), 0);
        for (int i = 0; i < 9; i++) run_frame(VEC[i]);
        repeat (3) @(negedge clk);
        chk(!busy && !out_valid, "R2 idle between frames", int'({busy, out_valid}), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule